// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block makes the master clock, bit clock and word-select lines for a serial audio port that runs as clock master. It runs on a kernel clock and divides it by a programmable ratio. The ratio is twice an 8-bit prescale value plus an odd-adjust bit, and a zero setting means divide by one. The divided clock can appear on a master clock line. The bit clock is then a fixed fraction of that master clock, so the master clock runs at 256 (standard framing) or 128 (short-frame/PCM framing) times the frame rate. When the master clock is switched off, the divided clock is the bit clock itself.

The divided clock is produced synchronously to the kernel clock. A divide-by-one setting therefore makes the divider advance on every kernel cycle, and the result is seen in the timing of the derived lines. Configuration arrives as plain register fields. Prescale, odd bit and framing mode are copied into a working set while the port is stopped, or at a frame boundary while it runs, so a change never cuts a pulse short. When the port is disabled, a hold control keeps the bit clock and word select driven at their inactive levels. Without it, the output enable drops.

Top module: `aud_clkgen`

## Requirements
- R1: With the master clock disabled, the bit clock period is N = 2*div_i + odd_i kernel cycles.
- R2: div_i = 0 with odd_i = 0 gives a ratio of one, so the divider advances on every kernel cycle. With the master clock enabled, the bit clock period is then 8 cycles (wide_i = 0) or 4 cycles (wide_i = 1).
- R3: div_i = 1 with odd_i = 1 is forbidden. cfg_err_o goes high one cycle later, and a stopped port does not start: the bit clock stays at its inactive level and ws_o stays low.
- R4: With mclk_en_i = 1, mclk_o has period N and the bit period is 8*N (wide_i = 0) or 4*N (wide_i = 1). This gives 256x or 128x the frame rate for the two framing modes.
- R5: A frame holds 32 bits (standard, dsp_i = 0) or 16 bits (dsp_i = 1), doubled when wide_i = 1. In standard framing ws_o is low for the first half of the frame and high for the second half. In short framing ws_o is high for the first bit period only.
- R6: ckpol_i = 1 inverts bclk_o: the idle level becomes 1, and the phase that lasts ceil(N/2) cycles becomes low.
- R7: While the port is not running, bclk_o equals ckpol_i and ws_o and mclk_o are low. oe_o is registered as en_i OR hold_i. After reset all outputs are 0.
- R8: For any ratio of two or more, the high phase of the divided clock lasts ceil(N/2) kernel cycles and the low phase lasts floor(N/2).
- R9: A change of div_i, odd_i, mclk_en_i, dsp_i or wide_i made while the port runs takes effect only at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Port enable |
| hold_i | input | 1 | Keep lines driven at inactive levels while disabled |
| ckpol_i | input | 1 | Bit clock polarity inversion |
| div_i | input | 8 | Prescale value |
| odd_i | input | 1 | Odd-adjust bit added to the ratio |
| mclk_en_i | input | 1 | Master clock output enable |
| dsp_i | input | 1 | Short (PCM) framing select |
| wide_i | input | 1 | Double channel length |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select / frame sync |
| oe_o | output | 1 | Output enable for the clock and frame lines |
| cfg_err_o | output | 1 | Forbidden divider setting present |

## Verification
The assertions assume the configuration inputs are synchronous to the kernel clock and change only between cycles. They also assume a running port has been enabled for at least one edge before its working set is judged. The stimulus changes settings only at the falling clock edge. It stops the port before changing the framing mode, except in the one scenario that deliberately updates the prescale mid-frame. That scenario makes the change just after a word-select rising edge, so the rest of the frame is long enough to observe the old ratio before the boundary.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
  localparam int DEF_DIV_W = 8;

  typedef struct packed {
    logic mclk_en;
    logic dsp;
    logic wide;
  } mode_t;
endpackage

// File: rtl/aud_clkgen_div.sv
module aud_clkgen_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  output logic             tick,
  output logic             lvl
);
  localparam int NW = DIV_W + 1;

  logic [NW-1:0] n_raw, n, n_m1, half, cnt;
  logic [NW:0]   n_p1;

  assign n_raw = {div, 1'b0} + {{DIV_W{1'b0}}, odd};
  assign n     = (n_raw == '0) ? {{(NW-1){1'b0}}, 1'b1} : n_raw;
  assign n_m1  = n - {{(NW-1){1'b0}}, 1'b1};
  assign n_p1  = {1'b0, n} + {{NW{1'b0}}, 1'b1};
  assign half  = n_p1[NW:1];

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt >= n_m1) cnt <= '0;
    else                 cnt <= cnt + {{(NW-1){1'b0}}, 1'b1};
  end

  assign tick = run && (cnt == n_m1);
  assign lvl  = cnt < half;
endmodule

// File: rtl/aud_clkgen_frame.sv
module aud_clkgen_frame
  import aud_clkgen_pkg::*;
#(
  parameter int SUB_MAX  = 8,
  parameter int SLOT_STD = 32,
  parameter int SLOT_DSP = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  tick,
  input  logic  lvl,
  input  mode_t mode,
  output logic  bclk_raw,
  output logic  ws_raw,
  output logic  frame_end
);
  localparam int SW = $clog2(SUB_MAX);
  localparam int BW = $clog2(2 * SLOT_STD);

  logic [SW-1:0] sc, k_m1, k_half;
  logic [BW-1:0] bc, f_m1, f_half;
  logic          bit_end;

  assign k_m1   = mode.wide ? SW'(SUB_MAX/2 - 1) : SW'(SUB_MAX - 1);
  assign k_half = mode.wide ? SW'(SUB_MAX/4) : SW'(SUB_MAX/2);

  always_comb begin
    case ({mode.dsp, mode.wide})
      2'b00:   begin f_m1 = BW'(SLOT_STD - 1);   f_half = BW'(SLOT_STD/2); end
      2'b01:   begin f_m1 = BW'(2*SLOT_STD - 1); f_half = BW'(SLOT_STD);   end
      2'b10:   begin f_m1 = BW'(SLOT_DSP - 1);   f_half = BW'(SLOT_DSP/2); end
      default: begin f_m1 = BW'(2*SLOT_DSP - 1); f_half = BW'(SLOT_DSP);   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run)                sc <= '0;
    else if (tick && mode.mclk_en)  sc <= (sc == k_m1) ? '0 : sc + {{(SW-1){1'b0}}, 1'b1};
  end

  assign bit_end = mode.mclk_en ? (tick && sc == k_m1) : tick;

  always_ff @(posedge clk) begin
    if (rst || !run)  bc <= '0;
    else if (bit_end) bc <= (bc == f_m1) ? '0 : bc + {{(BW-1){1'b0}}, 1'b1};
  end

  assign frame_end = bit_end && (bc == f_m1);
  assign bclk_raw  = mode.mclk_en ? (sc < k_half) : lvl;
  assign ws_raw    = mode.dsp ? (bc == '0) : (bc >= f_half);
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter int DIV_W    = DEF_DIV_W,
  parameter int SUB_MAX  = 8,
  parameter int SLOT_STD = 32,
  parameter int SLOT_DSP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             ckpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             dsp_i,
  input  logic             wide_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             oe_o,
  output logic             cfg_err_o
);
  logic             forbidden, run_q, tick, lvl, bclk_raw, ws_raw, frame_end;
  logic [DIV_W-1:0] div_s;
  logic             odd_s;
  mode_t            mode_s;

  assign forbidden = (div_i == DIV_W'(1)) && odd_i;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= en_i && (run_q || !forbidden);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_s  <= '0;
      odd_s  <= 1'b0;
      mode_s <= '0;
    end else if (!run_q || (frame_end && !forbidden)) begin
      div_s  <= div_i;
      odd_s  <= odd_i;
      mode_s <= '{mclk_en: mclk_en_i, dsp: dsp_i, wide: wide_i};
    end
  end

  aud_clkgen_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .div(div_s), .odd(odd_s),
    .tick(tick), .lvl(lvl)
  );

  aud_clkgen_frame #(.SUB_MAX(SUB_MAX), .SLOT_STD(SLOT_STD), .SLOT_DSP(SLOT_DSP)) u_frame (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick), .lvl(lvl), .mode(mode_s),
    .bclk_raw(bclk_raw), .ws_raw(ws_raw), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o    <= 1'b0;
      bclk_o    <= 1'b0;
      ws_o      <= 1'b0;
      oe_o      <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      mclk_o    <= run_q && mode_s.mclk_en && lvl;
      bclk_o    <= run_q ? (bclk_raw ^ ckpol_i) : ckpol_i;
      ws_o      <= run_q && ws_raw;
      oe_o      <= en_i || hold_i;
      cfg_err_o <= forbidden;
    end
  end
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             hold_i,
  input logic             ckpol_i,
  input logic [DIV_W-1:0] div_i,
  input logic             odd_i,
  input logic             run_q,
  input logic             frame_end,
  input logic [DIV_W-1:0] div_s,
  input logic             odd_s,
  input logic             bclk_o,
  input logic             ws_o,
  input logic             oe_o
);
  a_r3_no_start: assert property (@(posedge clk) disable iff (rst)
    (div_i == DIV_W'(1) && odd_i && !run_q) |=> !run_q);

  a_r7_idle_bclk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (bclk_o == $past(ckpol_i)));

  a_r7_idle_ws: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !ws_o);

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !hold_i) |=> !oe_o);

  a_r9_hold_div: assert property (@(posedge clk) disable iff (rst)
    (run_q && !frame_end) |=> ($stable(div_s) && $stable(odd_s)));
endmodule

bind aud_clkgen aud_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .hold_i(hold_i), .ckpol_i(ckpol_i),
  .div_i(div_i), .odd_i(odd_i), .run_q(run_q), .frame_end(frame_end),
  .div_s(div_s), .odd_s(odd_s), .bclk_o(bclk_o), .ws_o(ws_o), .oe_o(oe_o)
);

// File: tb/aud_clkgen_test.sv
module aud_clkgen_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic       en_i = 0, hold_i = 0, ckpol_i = 0, odd_i = 0;
  logic       mclk_en_i = 0, dsp_i = 0, wide_i = 0;
  logic [7:0] div_i = 0;
  logic       mclk_o, bclk_o, ws_o, oe_o, cfg_err_o;
  int         total = 0, fails = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  aud_clkgen uut (
    .clk(clk), .rst(rst), .en_i(en_i), .hold_i(hold_i), .ckpol_i(ckpol_i),
    .div_i(div_i), .odd_i(odd_i), .mclk_en_i(mclk_en_i), .dsp_i(dsp_i),
    .wide_i(wide_i), .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
    .oe_o(oe_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return mclk_o;
      1: return bclk_o;
      default: return ws_o;
    endcase
  endfunction

  task automatic measure(input int sel, output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (pick(sel) != 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (pick(sel) != 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    while (pick(sel) == 1'b1 && guard < 4000) begin @(negedge clk); hi++; guard++; end
    while (pick(sel) == 1'b0 && guard < 4000) begin @(negedge clk); lo++; guard++; end
    if (guard >= 4000) begin hi = -1; lo = -1; end
  endtask

  task automatic setup(input int dv, input bit od, input bit mc, input bit ds,
                       input bit wd, input bit pol);
    @(negedge clk);
    en_i = 0;
    repeat (3) @(negedge clk);
    div_i = 8'(dv); odd_i = od; mclk_en_i = mc; dsp_i = ds; wide_i = wd; ckpol_i = pol;
    @(negedge clk);
    en_i = 1;
  endtask

  task automatic t_reset;
    chk("R7 reset oe", oe_o, 0);
    chk("R7 reset bclk", bclk_o, 0);
    chk("R7 reset ws", ws_o, 0);
    chk("R7 reset mclk", mclk_o, 0);
    chk("R7 reset err", cfg_err_o, 0);
  endtask

  task automatic t_idle;
    @(negedge clk); hold_i = 1; ckpol_i = 1;
    repeat (2) @(negedge clk);
    chk("R7 hold oe", oe_o, 1);
    chk("R6 idle bclk level", bclk_o, 1);
    chk("R7 idle ws", ws_o, 0);
    hold_i = 0;
    repeat (2) @(negedge clk);
    chk("R7 released oe", oe_o, 0);
    ckpol_i = 0;
  endtask

  task automatic t_plain;
    int h, l;
    setup(2, 0, 0, 0, 0, 0); measure(1, h, l);
    chk("R1 N=4 bclk period", h + l, 4);
    setup(2, 1, 0, 0, 0, 0); measure(1, h, l);
    chk("R8 N=5 high", h, 3); chk("R8 N=5 low", l, 2);
    setup(3, 0, 0, 0, 0, 0); measure(1, h, l);
    chk("R1 N=6 bclk period", h + l, 6);
    setup(1, 0, 0, 0, 0, 0); measure(2, h, l);
    chk("R5 std ws high", h, 32); chk("R5 std ws low", l, 32);
    setup(1, 0, 0, 0, 1, 0); measure(2, h, l);
    chk("R5 std wide ws high", h, 64); chk("R5 std wide ws low", l, 64);
  endtask

  task automatic t_dsp;
    int h, l;
    setup(1, 0, 0, 1, 0, 0); measure(2, h, l);
    chk("R5 dsp ws high", h, 2); chk("R5 dsp ws low", l, 30);
    setup(1, 0, 0, 1, 1, 0); measure(2, h, l);
    chk("R5 dsp wide ws low", l, 62);
  endtask

  task automatic t_mclk;
    int h, l;
    setup(3, 1, 1, 0, 0, 0); measure(0, h, l);
    chk("R8 mclk high", h, 4); chk("R8 mclk low", l, 3);
    measure(1, h, l);
    chk("R4 bclk 8N", h + l, 56);
    setup(3, 1, 1, 0, 1, 0); measure(1, h, l);
    chk("R4 bclk 4N wide", h + l, 28);
    setup(0, 0, 1, 0, 1, 0); measure(1, h, l);
    chk("R2 ratio one wide", h + l, 4);
    setup(0, 0, 1, 0, 0, 0); measure(1, h, l);
    chk("R2 ratio one narrow", h + l, 8);
  endtask

  task automatic t_pol;
    int h, l;
    setup(2, 1, 0, 0, 0, 1); measure(1, h, l);
    chk("R6 inverted high", h, 2); chk("R6 inverted low", l, 3);
  endtask

  task automatic t_forbidden;
    int h, l, moved;
    setup(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3 error flag", cfg_err_o, 1);
    moved = 0;
    repeat (40) begin @(negedge clk); if (bclk_o || ws_o) moved = 1; end
    chk("R3 stays stopped", moved, 0);
    div_i = 2; odd_i = 0;
    repeat (2) @(negedge clk);
    chk("R3 error cleared", cfg_err_o, 0);
    measure(1, h, l);
    chk("R3 starts once legal", h + l, 4);
  endtask

  task automatic t_deferred;
    int h, l;
    setup(2, 0, 0, 0, 0, 0);
    measure(2, h, l);
    div_i = 3;
    measure(1, h, l);
    chk("R9 old ratio until frame end", h + l, 4);
    measure(2, h, l);
    chk("R9 new ratio after frame end", h, 96);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_plain();
    t_dsp();
    t_mclk();
    t_pol();
    t_forbidden();
    t_deferred();
    done = 1;
    summary();
    $finish;
  end
endmodule